// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block runs a complete serial-flash read without software moving each byte. It sits above a byte-wide SPI exchange engine and drives that engine's handshake: a select write (chip select on or off), a transmit-byte load, a start strobe, the engine's ready status and its received byte. A request carries an opcode, a 24-bit address and a byte count. The sequencer selects the memory and sends the opcode and then the three address bytes. It then runs one dummy exchange for each byte to be read and hands each received byte to a valid/ready output stream. At the end it deselects the memory and pulses done.

Every exchange follows the same order. The sequencer waits for the engine to report ready, loads the transmit byte, waits for ready again, issues start, and waits for ready to come back. The received byte is taken only at that last point. Bytes that arrive during the opcode and address exchanges are dropped. When the output stream is stalled, the sequencer does not start the next dummy exchange, so no data byte is ever lost and no output storage beyond one byte is needed.

Top module: `frs_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and out_valid are low, and no select write, load or start strobe is driven to the engine.
- R2: A request is taken only while busy is low. A request raised while busy is high is ignored: it adds no exchange and does not change the header being sent.
- R3: A select write with eng_sel_on=1 comes before the first exchange of a request. Chip select stays low (selected) through every exchange of the request. The select write with eng_sel_on=0 is issued in the cycle in which done is high.
- R4: The first four exchanges of a request transmit, in this order, the opcode, address bits 23:16, address bits 15:8 and address bits 7:0.
- R5: After the header, exactly as many exchanges follow as the byte count gives, and each one transmits 0x00.
- R6: For every exchange the sequencer first pulses eng_tx_load and then, in a later cycle, eng_start. Both strobes are issued only while eng_ready is high. The engine is expected to drop eng_ready in the cycle after it samples start.
- R7: Bytes received during header exchanges are discarded. The output stream carries, in order, the value on eng_rx_byte at the moment eng_ready returns high after each dummy exchange, and it holds out_data stable while out_ready is low.
- R8: While a delivered byte has not yet been accepted (out_valid high), no eng_start is issued.
- R9: A byte count of zero performs the four header exchanges only, delivers no byte, then deselects and pulses done.
- R10: done is high for exactly one cycle and only after the last data byte has been accepted. busy is high from the cycle after a request is taken up to and including the done cycle, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request strobe, taken while busy is low |
| req_opcode | input | 8 | Read command opcode |
| req_addr | input | 24 | Start address in the flash |
| req_count | input | 16 | Number of data bytes to read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| out_valid | output | 1 | A received data byte is offered |
| out_data | output | 8 | Received data byte |
| out_ready | input | 1 | Downstream accepts the offered byte |
| eng_sel_wr | output | 1 | Select write strobe to the engine |
| eng_sel_on | output | 1 | Select value: 1 lowers chip select, 0 raises it |
| eng_tx_load | output | 1 | Load strobe for the transmit byte |
| eng_tx_byte | output | 8 | Byte to be transmitted, most significant bit first |
| eng_start | output | 1 | Start one byte exchange |
| eng_ready | input | 1 | Engine idle and previous exchange complete |
| eng_rx_byte | input | 8 | Byte received in the last exchange |

## Verification
The hardest case to reach from the ports is a stalled output that overlaps the point where the next dummy exchange would begin. In that case a careless sequencer starts an exchange while it still holds an unaccepted byte. The bench has a consumer that keeps out_ready low well beyond the length of one engine exchange after each byte it takes. A monitor flags any start seen while out_valid is high. The engine model also drives a garbage value on its receive byte while an exchange is in progress, so a byte taken too early does not match the expected value.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LOAD,
    ST_START,
    ST_WAIT,
    ST_DRAIN,
    ST_DESEL
  } frs_state_e;
endpackage

// File: rtl/frs_hdr_mux.sv
module frs_hdr_mux #(
  parameter int ADDR_BYTES = 3,
  parameter int IDX_W      = 3
) (
  input  logic [7:0]              opcode,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [IDX_W-1:0]        idx,
  output logic [7:0]              hdr_byte
);
  // index 0 selects the opcode, index k selects address byte k counted from the top
  always_comb begin
    hdr_byte = opcode;
    for (int k = 1; k <= ADDR_BYTES; k++) begin
      if (idx == IDX_W'(k)) begin
        hdr_byte = addr[8*(ADDR_BYTES-k) +: 8];
      end
    end
  end
endmodule

// File: rtl/frs_count.sv
module frs_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == W'(1));

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero); // R5
endmodule

// File: rtl/frs_outbuf.sv
module frs_outbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic       valid_q;
  logic       valid_d;
  logic [7:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (push) begin
      valid_d = 1'b1;
    end else if (valid_q && out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
    end else if (push) begin
      data_q <= push_byte;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_OBUF_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid_q); // R8
  AST_OBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(data_q))); // R7
endmodule

// File: rtl/frs_seq.sv
module frs_seq #(
  parameter int         CNT_W      = 16,
  parameter int         ADDR_BYTES = 3,
  parameter logic [7:0] DUMMY_BYTE = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [7:0]              req_opcode,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [CNT_W-1:0]        req_count,
  output logic                    busy,
  output logic                    done,
  output logic                    out_valid,
  output logic [7:0]              out_data,
  input  logic                    out_ready,
  output logic                    eng_sel_wr,
  output logic                    eng_sel_on,
  output logic                    eng_tx_load,
  output logic [7:0]              eng_tx_byte,
  output logic                    eng_start,
  input  logic                    eng_ready,
  input  logic [7:0]              eng_rx_byte
);
  import frs_pkg::*;

  localparam int HDR_N = ADDR_BYTES + 1;
  localparam int IDX_W = $clog2(HDR_N + 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  frs_state_e              state_q, state_d;
  logic [7:0]              op_q;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic                    idx_en;
  logic                    in_data_q, in_data_d, in_data_en;
  logic                    req_take;
  logic                    cnt_dec;
  logic                    cnt_zero, cnt_one;
  logic                    ob_push;
  logic [7:0]              hdr_byte;
  logic                    hdr_last;

  frs_hdr_mux #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_hdr (
    .opcode  (op_q),
    .addr    (addr_q),
    .idx     (idx_q),
    .hdr_byte(hdr_byte)
  );

  frs_count #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (req_take),
    .load_val(req_count),
    .dec     (cnt_dec),
    .is_zero (cnt_zero),
    .is_one  (cnt_one)
  );

  frs_outbuf u_obuf (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (ob_push),
    .push_byte(eng_rx_byte),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  assign hdr_last = (idx_q == IDX_W'(HDR_N - 1));

  // next-state and strobe logic
  always_comb begin
    state_d     = state_q;
    req_take    = 1'b0;
    idx_en      = 1'b0;
    idx_d       = idx_q;
    in_data_en  = 1'b0;
    in_data_d   = in_data_q;
    cnt_dec     = 1'b0;
    ob_push     = 1'b0;
    eng_sel_wr  = 1'b0;
    eng_sel_on  = 1'b0;
    eng_tx_load = 1'b0;
    eng_start   = 1'b0;
    done        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_take   = 1'b1;
          idx_en     = 1'b1;
          idx_d      = '0;
          in_data_en = 1'b1;
          in_data_d  = 1'b0;
          state_d    = ST_SEL;
        end
      end
      ST_SEL: begin
        eng_sel_wr = 1'b1;
        eng_sel_on = 1'b1;
        state_d    = ST_LOAD;
      end
      ST_LOAD: begin
        // in the data phase a held output byte blocks the next dummy
        if (eng_ready && !(in_data_q && out_valid)) begin
          eng_tx_load = 1'b1;
          state_d     = ST_START;
        end
      end
      ST_START: begin
        if (eng_ready) begin
          eng_start = 1'b1;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (eng_ready) begin
          if (in_data_q) begin
            ob_push = 1'b1;
            cnt_dec = 1'b1;
            state_d = cnt_one ? ST_DRAIN : ST_LOAD;
          end else if (hdr_last) begin
            if (cnt_zero) begin
              state_d = ST_DESEL;
            end else begin
              in_data_en = 1'b1;
              in_data_d  = 1'b1;
              state_d    = ST_LOAD;
            end
          end else begin
            idx_en  = 1'b1;
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_LOAD;
          end
        end
      end
      ST_DRAIN: begin
        if (!out_valid) begin
          state_d = ST_DESEL;
        end
      end
      ST_DESEL: begin
        eng_sel_wr = 1'b1;
        eng_sel_on = 1'b0;
        done       = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q   <= 8'h00;
      addr_q <= '0;
    end else if (req_take) begin
      op_q   <= req_opcode;
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      in_data_q <= 1'b0;
    end else if (in_data_en) begin
      in_data_q <= in_data_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign eng_tx_byte = in_data_q ? DUMMY_BYTE : hdr_byte;

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_tx_load |-> eng_ready); // R6
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_start |-> eng_ready); // R6
  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_start |-> $past(eng_tx_load)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done); // R10
  AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (eng_sel_wr && !eng_sel_on)); // R3
  AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !out_valid); // R10
  AST_NO_START_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eng_start && in_data_q) |-> !out_valid); // R8
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !done) |=> busy); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (!eng_start && !eng_tx_load && !eng_sel_wr)); // R2
endmodule

// File: tb/frs_seq_bench.sv
`timescale 1ns/1ps
module frs_seq_bench;
  localparam int HN  = 4;
  localparam int LAT = 6;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [15:0] cnt;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h03, 24'h123456, 16'd4, 1'b0},
    '{8'h0B, 24'hABCDEF, 16'd1, 1'b1},
    '{8'h03, 24'h000000, 16'd0, 1'b0},
    '{8'h03, 24'hFFFFFE, 16'd6, 1'b1},
    '{8'h5A, 24'h00F00F, 16'd3, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = 8'h00;
  logic [23:0] req_addr = 24'h0;
  logic [15:0] req_count = 16'h0;
  logic        busy, done, out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        eng_sel_wr, eng_sel_on, eng_tx_load, eng_start;
  logic [7:0]  eng_tx_byte;
  logic        eng_ready;
  logic [7:0]  eng_rx_byte;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  frs_seq u_frs_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_addr(req_addr), .req_count(req_count),
    .busy(busy), .done(done),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .eng_sel_wr(eng_sel_wr), .eng_sel_on(eng_sel_on), .eng_tx_load(eng_tx_load),
    .eng_tx_byte(eng_tx_byte), .eng_start(eng_start), .eng_ready(eng_ready),
    .eng_rx_byte(eng_rx_byte)
  );

  function automatic logic [7:0] rxf(input int n);
    return 8'(n * 37 + 91);
  endfunction

  // byte engine model
  logic       ss_n;
  logic [7:0] txr;
  int         ctr;
  int         nx = 0;
  int         v_load = 0;
  int         v_start = 0;
  int         v_cs = 0;
  logic [7:0] log_tx [0:1023];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_n        <= 1'b1;
      eng_ready   <= 1'b1;
      eng_rx_byte <= 8'h00;
      txr         <= 8'h00;
      ctr         <= 0;
    end else begin
      if (eng_sel_wr) ss_n <= !eng_sel_on;
      if (eng_tx_load) begin
        if (!eng_ready) v_load <= v_load + 1;
        else txr <= eng_tx_byte;
      end
      if (eng_start) begin
        if (!eng_ready) v_start <= v_start + 1;
        if (ss_n) v_cs <= v_cs + 1;
        eng_ready   <= 1'b0;
        ctr         <= LAT;
        log_tx[nx]  <= txr;
        nx          <= nx + 1;
        eng_rx_byte <= 8'hEE;
      end else if (!eng_ready) begin
        if (ctr <= 1) begin
          eng_ready   <= 1'b1;
          eng_rx_byte <= rxf(nx - 1);
        end else begin
          ctr <= ctr - 1;
        end
      end
    end
  end

  // consumer and monitor, away from the active edge
  logic       stall_mode = 1'b0;
  int         hold = 0;
  int         nr = 0;
  int         v_stall = 0;
  int         dones = 0;
  logic [7:0] rcv [0:1023];

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      rcv[nr] = out_data;
      nr = nr + 1;
      hold = stall_mode ? 25 : 0;
    end
    if (eng_start && out_valid) v_stall = v_stall + 1;
    if (done) dones = dones + 1;
    out_ready = (hold == 0);
    if (hold > 0) hold = hold - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    seen = 1'b0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    seen = done;
  endtask

  task automatic run_vec(input vec_t v);
    int nx0 = nx;
    int nr0 = nr;
    int d0  = dones;
    int vl0 = v_load, vs0 = v_start, vc0 = v_cs, vh0 = v_stall;
    int bad_dummy = 0;
    int bad_data  = 0;
    bit seen;
    stall_mode = v.stall;
    @(negedge clk);
    req_opcode = v.op; req_addr = v.addr; req_count = v.cnt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after take", int'(busy), 1);
    wait_done(seen);
    chk(seen, "R10 done seen", int'(seen), 1);
    chk(busy == 1'b1, "R10 busy in done cycle", int'(busy), 1);
    chk(ss_n == 1'b0, "R3 chip select low until release", int'(ss_n), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy low after done", int'(busy), 0);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    chk(ss_n == 1'b1, "R3 chip select released", int'(ss_n), 1);
    chk(dones - d0 == 1, "R10 single done", dones - d0, 1);
    chk(nx - nx0 == HN + int'(v.cnt), v.cnt == 0 ? "R9 header-only exchange count" : "R5 exchange count",
        nx - nx0, HN + int'(v.cnt));
    chk(log_tx[nx0] == v.op, "R4 opcode byte", int'(log_tx[nx0]), int'(v.op));
    chk(log_tx[nx0+1] == v.addr[23:16], "R4 address high", int'(log_tx[nx0+1]), int'(v.addr[23:16]));
    chk(log_tx[nx0+2] == v.addr[15:8], "R4 address mid", int'(log_tx[nx0+2]), int'(v.addr[15:8]));
    chk(log_tx[nx0+3] == v.addr[7:0], "R4 address low", int'(log_tx[nx0+3]), int'(v.addr[7:0]));
    for (int i = 0; i < int'(v.cnt); i++) begin
      if (log_tx[nx0+HN+i] != 8'h00) bad_dummy++;
    end
    chk(bad_dummy == 0, "R5 dummy bytes zero", bad_dummy, 0);
    chk(nr - nr0 == int'(v.cnt), v.cnt == 0 ? "R9 no data delivered" : "R7 data count",
        nr - nr0, int'(v.cnt));
    for (int i = 0; i < int'(v.cnt); i++) begin
      if (rcv[nr0+i] != rxf(nx0 + HN + i)) begin
        if (bad_data == 0)
          chk(1'b0, "R7 data byte", int'(rcv[nr0+i]), int'(rxf(nx0 + HN + i)));
        bad_data++;
      end
    end
    if (bad_data == 0) chk(1'b1, "R7 data bytes", 0, 0);
    chk(v_load == vl0 && v_start == vs0, "R6 strobes only while ready",
        (v_load - vl0) + (v_start - vs0), 0);
    chk(v_cs == vc0, "R3 no exchange while deselected", v_cs - vc0, 0);
    chk(v_stall == vh0, "R8 no start while byte held", v_stall - vh0, 0);
  endtask

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int nx0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 outputs in reset", int'({busy, done, out_valid}), 0);
    chk(!eng_sel_wr && !eng_tx_load && !eng_start, "R1 engine strobes in reset",
        int'({eng_sel_wr, eng_tx_load, eng_start}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 outputs after reset", int'({busy, done, out_valid}), 0);
    chk(nx == 0 && ss_n == 1'b1, "R1 no exchange after reset", nx, 0);

    for (int i = 0; i < 5; i++) run_vec(VEC[i]);

    // request raised while busy must be ignored
    nx0 = nx;
    stall_mode = 1'b0;
    @(negedge clk);
    req_opcode = 8'h03; req_addr = 24'h111111; req_count = 16'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_opcode = 8'hC7; req_addr = 24'h999999; req_count = 16'd9; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(seen, "R10 done for first request", int'(seen), 1);
    repeat (40) @(negedge clk);
    chk(nx - nx0 == HN + 2, "R2 ignored request adds no exchange", nx - nx0, HN + 2);
    chk(log_tx[nx0] == 8'h03, "R2 header unchanged", int'(log_tx[nx0]), 8'h03);
    chk(busy == 1'b0, "R2 idle after ignored request", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule